// File: doc/BRIEF.md
# Serial GPIO shift engine

This block is the master side of a serial GPIO expander. It drives a shift clock, a load strobe and a serial data line to a chain of external shift registers that holds output pins, and it reads a serial data line back from a second chain that samples input pins. Software writes the output pin values into byte-wide bank registers. It reads the sampled input pins from a second set of byte-wide bank registers. A small set of configuration bytes chooses the shift clock rate, the polarity of the clock and the strobe, and how many 8-pin ports each chain holds.

While the interface is enabled in continuous mode, the engine scans without a break. Each scan opens with one shift-clock period of load strobe. It then gives one shift clock per bit for the longer of the two chains, and at the end commits the newly captured input bits. The register interface is a plain byte bus: an address, write data and a write enable, with combinational read data.

Top module: `sgx_engine`

## Requirements
- R1: The output bank for bank n (n = 0..7) is at offset n and reads back what was last written. The input bank for bank n is at offset 8+n and is read-only: a write there leaves its content unchanged. Bank n holds pins 8n..8n+7, with bit 0 being pin 8n.
- R2: The control byte is at offset 0x10, the clock byte at 0x11 and the port byte at 0x12. Each one reads back the full value last written. Every register is zero after reset.
- R3: Scanning runs only while control bit 7 is 1 and control bits [2:1] equal 2'b10. In any other setting, no strobe and no shift clock appear.
- R4: Clock byte bits [3:0] select the shift clock period in bus clocks: 0x0 gives 1024, 0x5 gives 32, 0x7 gives 8, 0xC gives 4, 0xD gives 3 and 0xE gives 2. Every other code gives 1024.
- R5: Clock byte bit 4 inverts the shift clock pin and bit 5 inverts the strobe pin. With both bits at 0, both pins idle low and are active high.
- R6: Each scan holds the strobe active for exactly one shift-clock period. It then gives L shift-clock pulses, where L is the larger of the output and input bit counts.
- R7: Port byte bits [7:4] give the number of output ports and bits [3:0] the number of input ports. Each port is 8 bits, and a count above 8 is treated as 8. During the L pulses the data pin first carries L minus the output bit count zeros. It then carries the output bits from the top pin downward (the MSB of the highest port first). The data pin is stable while the shift clock is active.
- R8: The serial input is sampled on the active edge of the shift clock. The first sampled bit becomes the top input pin, and the following bits fill the pins downward. Bits sampled after the input chain is exhausted are discarded.
- R9: Input banks are updated only when a scan completes. Banks at or above the input port count keep their contents.
- R10: Scans repeat back to back: the next strobe starts right after the last shift period, so scans begin (1+L) shift-clock periods apart.
- R11: Leaving the run setting stops the scan at the next bit boundary. The strobe and the shift clock then rest at their idle levels, and a partly captured scan is discarded.
- R12: When both port counts are zero, no scan is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 5 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| ser_clk | output | 1 | Shift clock to the chains |
| ser_load | output | 1 | Load/shift strobe to the chains |
| ser_dout | output | 1 | Serial data to the output chain |
| ser_din | input | 1 | Serial data from the input chain |

## Verification
The assertions check the following properties on every cycle:
- The strobe ends only at a shift-period boundary.
- Two period ticks are never adjacent.
- Losing the run condition idles the engine at the next boundary.
- A completed scan is followed at once by a new strobe.
- The input banks change only at a commit, and only within the input mask.

Only the bench scenarios can show the exact bit order on the data pin, where captured bits land, the period in bus clocks for each divisor code and the effect of the polarity bits. The bench shows these by modelling both external chains and measuring strobe width and scan spacing.

// File: rtl/sgx_pkg.sv
package sgx_pkg;
  localparam int BYTE_W = 8;
  localparam int DIVC_W = 10;   // phase counter, longest period 1024

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_SHIFT} scan_st_t;

  // period of one shift clock in bus clocks for a selector code
  function automatic logic [DIVC_W:0] div_of(input logic [3:0] code);
    case (code)
      4'h5:    return 11'd32;
      4'h7:    return 11'd8;
      4'hC:    return 11'd4;
      4'hD:    return 11'd3;
      4'hE:    return 11'd2;
      default: return 11'd1024;
    endcase
  endfunction

  // bit count of a chain from its port field, clamped to the bank count
  function automatic int unsigned port_bits(input logic [3:0] n, input int unsigned banks);
    int unsigned c;
    c = int'(n);
    if (c > banks) c = banks;
    return c * BYTE_W;
  endfunction
endpackage

// File: rtl/sgx_regs.sv
module sgx_regs #(
  parameter int NUM_BANKS = 8,
  parameter int ADDR_W    = 5,
  localparam int VEC_W    = NUM_BANKS * sgx_pkg::BYTE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]       wdata,
  input  logic             we,
  output logic [7:0]       rdata,
  output logic [VEC_W-1:0] out_vec,
  output logic [7:0]       ctrl,
  output logic [7:0]       clkcfg,
  output logic [7:0]       portcfg,
  input  logic             commit,
  input  logic [VEC_W-1:0] cap_vec,
  input  logic [VEC_W-1:0] cap_mask
);
  localparam int CTRL_OFS = 2 * NUM_BANKS;
  localparam int CLK_OFS  = CTRL_OFS + 1;
  localparam int PORT_OFS = CTRL_OFS + 2;

  logic [7:0] wr_q [NUM_BANKS];
  logic [7:0] rd_q [NUM_BANKS];
  logic [VEC_W-1:0] rd_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        wr_q[b] <= '0;
        rd_q[b] <= '0;
      end
      ctrl    <= '0;
      clkcfg  <= '0;
      portcfg <= '0;
    end else begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (we && int'(addr) == b) wr_q[b] <= wdata;
        if (commit)
          rd_q[b] <= (rd_q[b] & ~cap_mask[b*8 +: 8]) | (cap_vec[b*8 +: 8] & cap_mask[b*8 +: 8]);
      end
      if (we && int'(addr) == CTRL_OFS) ctrl    <= wdata;
      if (we && int'(addr) == CLK_OFS)  clkcfg  <= wdata;
      if (we && int'(addr) == PORT_OFS) portcfg <= wdata;
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_flat
    assign out_vec[b*8 +: 8] = wr_q[b];
    assign rd_vec[b*8 +: 8]  = rd_q[b];
  end

  always_comb begin
    rdata = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (int'(addr) == b)             rdata = wr_q[b];
      if (int'(addr) == NUM_BANKS + b) rdata = rd_q[b];
    end
    if (int'(addr) == CTRL_OFS) rdata = ctrl;
    if (int'(addr) == CLK_OFS)  rdata = clkcfg;
    if (int'(addr) == PORT_OFS) rdata = portcfg;
  end

  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(rd_vec));
  // R9
  rd_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> ((rd_vec & ~$past(cap_mask)) == $past(rd_vec & ~cap_mask)));
endmodule

// File: rtl/sgx_clkdiv.sv
module sgx_clkdiv (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [3:0] code,
  output logic       tick,
  output logic       mid,
  output logic       sclk_hi
);
  import sgx_pkg::*;

  logic [DIVC_W-1:0] cnt_q;
  logic [DIVC_W:0]   div;
  logic [DIVC_W:0]   half;
  logic [DIVC_W:0]   cnt_x;

  assign div   = div_of(code);
  assign half  = div >> 1;
  assign cnt_x = {1'b0, cnt_q};

  assign tick    = run && (cnt_x >= div - 11'd1);
  assign mid     = run && (cnt_x == half);
  assign sclk_hi = run && (cnt_x >= half);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (!run || tick)  cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  // R4
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/sgx_scan.sv
module sgx_scan #(
  parameter int VEC_W = 64,
  localparam int CNT_W = $clog2(VEC_W + 1),
  localparam int IDX_W = $clog2(VEC_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_req,
  input  logic             tick,
  input  logic             mid,
  input  logic             sdi,
  input  logic [VEC_W-1:0] out_vec,
  input  logic [CNT_W-1:0] obits,
  input  logic [CNT_W-1:0] ibits,
  output logic             busy,
  output logic             load_act,
  output logic             shift_act,
  output logic             sdo,
  output logic             commit,
  output logic [VEC_W-1:0] cap_vec,
  output logic [VEC_W-1:0] cap_mask
);
  import sgx_pkg::*;

  scan_st_t st_q;
  logic [CNT_W-1:0] step_q, len_q, ob_q, ib_q, lmax, oidx, iidx;
  logic [VEC_W-1:0] cap_q, cap_nxt;
  logic last;

  assign lmax      = (obits > ibits) ? obits : ibits;
  assign busy      = (st_q != ST_IDLE);
  assign load_act  = (st_q == ST_LOAD);
  assign shift_act = (st_q == ST_SHIFT);
  assign last      = (step_q == len_q - 1'b1);
  assign oidx      = len_q - step_q - 1'b1;
  assign iidx      = ib_q - step_q - 1'b1;
  assign sdo       = shift_act && (oidx < ob_q) && out_vec[oidx[IDX_W-1:0]];
  assign commit    = shift_act && tick && run_req && last;
  assign cap_vec   = cap_nxt;

  always_comb begin
    cap_nxt = cap_q;
    if (shift_act && mid && (step_q < ib_q)) cap_nxt[iidx[IDX_W-1:0]] = sdi;
    for (int i = 0; i < VEC_W; i++) cap_mask[i] = (CNT_W'(i) < ib_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      step_q <= '0;
      len_q  <= '0;
      ob_q   <= '0;
      ib_q   <= '0;
      cap_q  <= '0;
    end else begin
      cap_q <= cap_nxt;
      unique case (st_q)
        ST_IDLE: if (run_req) begin
          st_q  <= ST_LOAD;
          len_q <= lmax;
          ob_q  <= obits;
          ib_q  <= ibits;
        end
        ST_LOAD: if (tick) begin
          if (!run_req) st_q <= ST_IDLE;
          else begin
            st_q   <= ST_SHIFT;
            step_q <= '0;
          end
        end
        ST_SHIFT: if (tick) begin
          if (!run_req) st_q <= ST_IDLE;
          else if (last) begin
            st_q  <= ST_LOAD;
            len_q <= lmax;
            ob_q  <= obits;
            ib_q  <= ibits;
          end else step_q <= step_q + 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R6
  ld_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(load_act) |-> $past(tick));
  // R11
  halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && tick && !run_req |=> !busy);
  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !run_req |=> !busy);
endmodule

// File: rtl/sgx_engine.sv
module sgx_engine #(
  parameter int NUM_BANKS = 8,
  parameter int ADDR_W    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  input  logic              reg_we,
  output logic [7:0]        reg_rdata,
  output logic              ser_clk,
  output logic              ser_load,
  output logic              ser_dout,
  input  logic              ser_din
);
  import sgx_pkg::*;

  localparam int VEC_W = NUM_BANKS * BYTE_W;
  localparam int CNT_W = $clog2(VEC_W + 1);

  logic [VEC_W-1:0] out_vec, cap_vec, cap_mask;
  logic [7:0] ctrl, clkcfg, portcfg;
  logic [CNT_W-1:0] obits, ibits;
  logic run_req, tick, mid, sclk_hi, busy, load_act, shift_act, commit;
  logic unused_cfg;

  assign obits   = CNT_W'(port_bits(portcfg[7:4], NUM_BANKS));
  assign ibits   = CNT_W'(port_bits(portcfg[3:0], NUM_BANKS));
  assign run_req = ctrl[7] && (ctrl[2:1] == 2'b10) && ((obits != '0) || (ibits != '0));
  assign unused_cfg = ^{ctrl[6:3], ctrl[0], clkcfg[7:6]};

  sgx_regs #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wdata(reg_wdata), .we(reg_we),
    .rdata(reg_rdata), .out_vec(out_vec), .ctrl(ctrl), .clkcfg(clkcfg),
    .portcfg(portcfg), .commit(commit), .cap_vec(cap_vec), .cap_mask(cap_mask));

  sgx_clkdiv u_div (
    .clk(clk), .rst_n(rst_n), .run(busy), .code(clkcfg[3:0]),
    .tick(tick), .mid(mid), .sclk_hi(sclk_hi));

  sgx_scan #(.VEC_W(VEC_W)) u_scan (
    .clk(clk), .rst_n(rst_n), .run_req(run_req), .tick(tick), .mid(mid),
    .sdi(ser_din), .out_vec(out_vec), .obits(obits), .ibits(ibits),
    .busy(busy), .load_act(load_act), .shift_act(shift_act), .sdo(ser_dout),
    .commit(commit), .cap_vec(cap_vec), .cap_mask(cap_mask));

  assign ser_clk  = clkcfg[4] ^ (shift_act & sclk_hi);
  assign ser_load = clkcfg[5] ^ load_act;

  // R10
  back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> load_act);
endmodule

// File: tb/sim_sgx_engine.sv
module sim_sgx_engine;
  logic clk = 0, rst_n = 0;
  logic [4:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic reg_we = 0;
  logic [7:0] reg_rdata;
  logic ser_clk, ser_load, ser_dout;
  logic ser_din = 1'b1;

  int nchk = 0, nfail = 0;
  bit done = 0;

  sgx_engine u0 (.clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata), .ser_clk(ser_clk), .ser_load(ser_load),
    .ser_dout(ser_dout), .ser_din(ser_din));

  always #5 clk = ~clk;

  // scoreboard of expected output streams
  int          q_len [$];
  logic [63:0] q_val [$];

  // monitor and chain-model state
  logic pol_c = 0, pol_l = 0, p_sc = 0, p_ld = 0;
  int cyc = 0, ld_t = 0, nbits = 0, ld_rises = 0, sc_rises = 0;
  bit have_prev = 0, mon_arm = 0;
  int exp_div = 2, exp_l = 8;
  logic [63:0] stream = '0, chain = '0, pat = '0;
  int pat_w = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    logic l_sc, l_ld;
    cyc++;
    l_sc = ser_clk ^ pol_c;
    l_ld = ser_load ^ pol_l;
    if (!l_sc && p_sc) chain = {chain[62:0], 1'b1};
    if (l_sc && !p_sc) begin
      stream = {stream[62:0], ser_dout};
      nbits++;
      sc_rises++;
    end
    if (l_ld && !p_ld) begin
      ld_rises++;
      if (nbits > 0 && q_len.size() > 0) begin
        chk("R7 stream length", 64'(nbits), 64'(q_len[0]));
        chk("R7 stream bits", stream, q_val[0]);
        void'(q_len.pop_front());
        void'(q_val.pop_front());
      end
      if (mon_arm && have_prev) chk("R10 scan spacing", 64'(cyc - ld_t), 64'((1 + exp_l) * exp_div));
      have_prev = 1;
      ld_t = cyc;
      nbits = 0;
      stream = '0;
      chain = pat;
    end
    if (!l_ld && p_ld && mon_arm) chk("R6 strobe width", 64'(cyc - ld_t), 64'(exp_div));
    ser_din = (pat_w > 0) ? chain[pat_w-1] : 1'b1;
    p_sc = l_sc;
    p_ld = l_ld;
  end

  task automatic mon_reset();
    @(posedge clk); #1;
    p_sc = ser_clk ^ pol_c;
    p_ld = ser_load ^ pol_l;
    nbits = 0; have_prev = 0; mon_arm = 0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic push(input int len, input logic [63:0] val);
    q_len.push_back(len);
    q_val.push_back(val);
  endtask

  task automatic drain(input string req);
    int n = 0;
    while (q_len.size() > 0 && n < 40000) begin @(negedge clk); n++; end
    chk(req, 64'(q_len.size()), 64'd0);
  endtask

  task automatic stop_scan();
    wr(5'h10, 8'h00);
    repeat (2100) @(negedge clk);
    q_len.delete(); q_val.delete();
    mon_reset();
  endtask

  initial begin
    repeat (5000000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [63:0] ov;
    int r0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    mon_reset();

    // reset state
    rd(5'h10, d); chk("R2 ctrl reset", 64'(d), 64'h0);
    rd(5'h12, d); chk("R2 port reset", 64'(d), 64'h0);
    chk("R5 idle clk", 64'(ser_clk), 64'h0);
    chk("R5 idle strobe", 64'(ser_load), 64'h0);

    // register map
    wr(5'h00, 8'hA5); wr(5'h01, 8'h3C); wr(5'h02, 8'h0F);
    rd(5'h00, d); chk("R1 bank0 readback", 64'(d), 64'hA5);
    rd(5'h02, d); chk("R1 bank2 readback", 64'(d), 64'h0F);
    wr(5'h08, 8'hFF);
    rd(5'h08, d); chk("R1 input bank ignores write", 64'(d), 64'h00);
    wr(5'h11, 8'h0E); rd(5'h11, d); chk("R2 clock byte readback", 64'(d), 64'h0E);
    wr(5'h12, 8'h21); rd(5'h12, d); chk("R2 port byte readback", 64'(d), 64'h21);
    wr(5'h10, 8'h04); rd(5'h10, d); chk("R2 ctrl readback", 64'(d), 64'h04);
    wr(5'h10, 8'h00);

    // two out ports, one in port, period 2; input longer tail of 1s discarded (R8)
    pat = 64'h96; pat_w = 8; exp_div = 2; exp_l = 16;
    mon_reset(); mon_arm = 1;
    push(16, 64'h3CA5); push(16, 64'h3CA5);
    wr(5'h10, 8'h84);
    drain("R7 two out ports");
    stop_scan();
    rd(5'h08, d); chk("R8 input bank0", 64'(d), 64'h96);
    rd(5'h09, d); chk("R9 bank above in count kept", 64'(d), 64'h00);

    // one out port, three in ports, period 3 (zero padding first)
    wr(5'h00, 8'hC3); wr(5'h12, 8'h13); wr(5'h11, 8'h0D);
    pat = 64'hA1B2C3; pat_w = 24; exp_div = 3; exp_l = 24;
    mon_reset(); mon_arm = 1;
    push(24, 64'hC3); push(24, 64'hC3);
    wr(5'h10, 8'h84);
    drain("R7 padded stream");
    stop_scan();
    rd(5'h08, d); chk("R8 input bank0", 64'(d), 64'hC3);
    rd(5'h09, d); chk("R8 input bank1", 64'(d), 64'hB2);
    rd(5'h0A, d); chk("R8 input bank2", 64'(d), 64'hA1);

    // inverted polarity, period 8, no input ports
    wr(5'h12, 8'h10); wr(5'h11, 8'h37);
    pol_c = 1; pol_l = 1;
    repeat (2) @(negedge clk);
    chk("R5 inverted idle clk", 64'(ser_clk), 64'h1);
    chk("R5 inverted idle strobe", 64'(ser_load), 64'h1);
    pat = 64'h0; pat_w = 8; exp_div = 8; exp_l = 8;
    mon_reset(); mon_arm = 1;
    push(8, 64'hC3); push(8, 64'hC3);
    wr(5'h10, 8'h84);
    drain("R5 R4 period 8");
    stop_scan();
    rd(5'h08, d); chk("R9 no input ports keeps bank0", 64'(d), 64'hC3);
    wr(5'h11, 8'h00); pol_c = 0; pol_l = 0;

    // unused selector code falls back to 1024
    wr(5'h12, 8'h01); wr(5'h11, 8'h03);
    pat = 64'h5A; pat_w = 8; exp_div = 1024; exp_l = 8;
    mon_reset(); mon_arm = 1;
    push(8, 64'h0);
    wr(5'h10, 8'h84);
    drain("R4 unused code");
    stop_scan();
    rd(5'h08, d); chk("R8 input after slow scan", 64'(d), 64'h5A);

    // stop mid-scan, period 4
    wr(5'h11, 8'h0C);
    pat = 64'hFF; pat_w = 8; exp_div = 4; exp_l = 8;
    mon_reset();
    wr(5'h10, 8'h84);
    while (!(ld_rises > 0 && nbits >= 3)) @(negedge clk);
    wr(5'h10, 8'h00);
    repeat (12) @(negedge clk);
    r0 = sc_rises;
    repeat (40) @(negedge clk);
    chk("R11 clock stopped", 64'(sc_rises), 64'(r0));
    chk("R11 strobe idle", 64'(ser_load), 64'h0);
    chk("R11 clock idle", 64'(ser_clk), 64'h0);
    rd(5'h08, d); chk("R11 partial scan discarded", 64'(d), 64'h5A);
    mon_reset();

    // enable without continuous mode, mode without enable
    r0 = ld_rises;
    wr(5'h10, 8'h82);
    repeat (300) @(negedge clk);
    chk("R3 wrong mode", 64'(ld_rises), 64'(r0));
    wr(5'h10, 8'h04);
    repeat (300) @(negedge clk);
    chk("R3 not enabled", 64'(ld_rises), 64'(r0));

    // both counts zero
    wr(5'h12, 8'h00); wr(5'h10, 8'h84);
    repeat (300) @(negedge clk);
    chk("R12 zero ports", 64'(ld_rises), 64'(r0));
    wr(5'h10, 8'h00);

    // counts above 8 clamp to 8 banks
    ov = '0;
    for (int b = 0; b < 8; b++) begin
      wr(5'(b), 8'(8'h11 * b + 1));
      ov[b*8 +: 8] = 8'(8'h11 * b + 1);
    end
    wr(5'h12, 8'h9F);
    pat = 64'h0123_4567_89AB_CDEF; pat_w = 64; exp_div = 4; exp_l = 64;
    mon_reset(); mon_arm = 1;
    push(64, ov); push(64, ov);
    wr(5'h10, 8'h84);
    drain("R7 clamped full chain");
    stop_scan();
    rd(5'h08, d); chk("R7 clamp input bank0", 64'(d), 64'hEF);
    rd(5'h0F, d); chk("R7 clamp input bank7", 64'(d), 64'h01);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule